// File: doc/BRIEF.md
# Banked Dual-Port Memory Arbiter

This block places a shared, banked RAM between two buses of a signal-processing core. One bus, the coefficient bus (X), carries coefficient and program fetches. The other, the data bus (Y), carries operand traffic. Each bus can issue one read or one write per instruction cycle. When the two buses target different banks, both are served in parallel. When they target the same bank, the data bus is served first. The coefficient access follows, and the core is held in the meantime.

Every write takes two clock cycles and every read takes one. The block raises `stall_o` in every cycle of a transaction except its last one. The core must keep both requests and their fields stable while `stall_o` is high, and it drops or changes them only after a cycle in which `stall_o` is low. Each port's `ready` pulses once, in the cycle where that port's access completes. For a read, the read data is valid in that same cycle.

The RAM is modelled as one array per bank. The top address bits choose the bank. The low `OFS_W` bits choose the word inside the bank. The address bits between those two fields are ignored, so locations alias.

Top module: `dpb_arbiter_top`

## Requirements
- R1: Out of reset, and with no request present, `x_ready_o`, `y_ready_o` and `stall_o` are all low.
- R2: The bank is the top log2(BANKS) address bits (default four banks: bits 15:14). The word inside the bank is the low OFS_W bits (default 8). Bits OFS_W to 13 are ignored, so 0x3F10 and 0x0010 reach the same word.
- R3: Reads from the two ports to different banks both complete in the request cycle, with `stall_o` low.
- R4: When both ports request the same bank, the Y access completes first. The X access begins only in the cycle after Y completes. Two same-bank reads take two cycles, with Y ready in cycle 0 and X ready in cycle 1.
- R5: A write takes two cycles. Its port's ready is high only in the second cycle, and `stall_o` is high in the first.
- R6: `stall_o` is high in every cycle of a transaction except the last. A transaction lasts as long as the longer of the two port schedules, where a port's schedule includes any wait behind Y. Examples: a same-bank Y write followed by an X write takes 4 cycles, and a different-bank X write with a Y read takes 2 cycles.
- R7: A read returns the most recently written value. A same-bank X read paired with a Y write to the same address returns the new Y data. A same-bank Y read paired with an X write returns the old data.
- R8: While its request is held across a stalled transaction, each port's ready pulses exactly once.
- R9: A port whose request is low never shows ready, even if its write-enable is high. Such a port does not modify the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_req_i | input | 1 | Coefficient-bus access request |
| x_we_i | input | 1 | Coefficient-bus write enable |
| x_addr_i | input | ADDR_W | Coefficient-bus word address |
| x_wdata_i | input | DATA_W | Coefficient-bus write data |
| y_req_i | input | 1 | Data-bus access request |
| y_we_i | input | 1 | Data-bus write enable |
| y_addr_i | input | ADDR_W | Data-bus word address |
| y_wdata_i | input | DATA_W | Data-bus write data |
| x_rdata_o | output | DATA_W | Coefficient-bus read data, valid with x_ready_o |
| y_rdata_o | output | DATA_W | Data-bus read data, valid with y_ready_o |
| x_ready_o | output | 1 | Coefficient-bus access completes this cycle |
| y_ready_o | output | 1 | Data-bus access completes this cycle |
| stall_o | output | 1 | Hold the core pipeline; transaction not finished |

## Verification
The bench walks same-bank collisions in every read/write mix: read-read, Y-write/X-read, X-write/Y-read and write-write. For each mix it checks the cycle in which each ready rises and each cycle of stall. A design that served X first, or let a write finish in one cycle, would show ready in the wrong cycle. A design that stalled for the wrong number of cycles would be caught by the per-cycle stall checks.

Same-address collisions in both directions check that data-first ordering is visible in the returned values. Aliased addresses check that the bank and offset are decoded from the right bits. A write-enable raised without a request is read back afterwards to show that it left memory untouched.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_BANKS  = 4;
  localparam int unsigned DEF_OFS_W  = 8;

  // per-port cycle status for the current transaction
  typedef struct packed {
    logic act;   // port uses its bank this cycle
    logic fin;   // access completes this cycle
    logic pend;  // access still outstanding after this cycle
    logic done;  // access already completed earlier in this transaction
  } port_stat_t;
endpackage

// File: rtl/dpb_addr_split.sv
module dpb_addr_split #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFS_W-1:0]  ofs_o
);
  // bank from top bits, word from bottom bits; middle bits alias
  assign bank_o = addr_i[ADDR_W-1 -: BANK_W];
  assign ofs_o  = addr_i[OFS_W-1:0];

  initial begin
    assert (BANK_W + OFS_W <= ADDR_W)
      else $error("bank and offset fields overlap");
  end
endmodule

// File: rtl/dpb_port_seq.sv
module dpb_port_seq
  import dpb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic       wait_i,   // bank held by the other port
  input  logic       stall_i,  // transaction continues next cycle
  output port_stat_t stat_o
);
  logic done_q, phase_q;
  logic act, fin;

  assign act = req_i & ~done_q & ~wait_i;
  assign fin = act & (~we_i | phase_q);

  assign stat_o.act  = act;
  assign stat_o.fin  = fin;
  assign stat_o.pend = req_i & ~done_q & ~fin;
  assign stat_o.done = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (!stall_i) begin
      done_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      done_q <= done_q | fin;
      if (fin)             phase_q <= 1'b0;
      else if (act && we_i) phase_q <= 1'b1;
    end
  end

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && stall_i) |=> done_q) else $error("done flag dropped mid-transaction"); // R8
endmodule

// File: rtl/dpb_bank_mem.sv
module dpb_bank_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned OFS_W  = 8,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned DEPTH  = 1 << OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] x_bank_i,
  input  logic [OFS_W-1:0]  x_ofs_i,
  input  logic              x_wr_i,
  input  logic [DATA_W-1:0] x_wdata_i,
  output logic [DATA_W-1:0] x_rdata_o,
  input  logic [BANK_W-1:0] y_bank_i,
  input  logic [OFS_W-1:0]  y_ofs_i,
  input  logic              y_wr_i,
  input  logic [DATA_W-1:0] y_wdata_i,
  output logic [DATA_W-1:0] y_rdata_o
);
  logic [DATA_W-1:0] x_rd_bank [BANKS];
  logic [DATA_W-1:0] y_rd_bank [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic x_sel, y_sel;
    logic              wr_en;
    logic [OFS_W-1:0]  wr_ofs;
    logic [DATA_W-1:0] wr_data;

    assign x_sel = x_wr_i && (x_bank_i == BANK_W'(b));
    assign y_sel = y_wr_i && (y_bank_i == BANK_W'(b));

    // arbiter never lets both ports write one bank in a cycle
    always_comb begin
      wr_en   = x_sel | y_sel;
      wr_ofs  = y_sel ? y_ofs_i : x_ofs_i;
      wr_data = y_sel ? y_wdata_i : x_wdata_i;
    end

    always_ff @(posedge clk_i) begin
      if (wr_en) mem_q[wr_ofs] <= wr_data;
    end

    assign x_rd_bank[b] = mem_q[x_ofs_i];
    assign y_rd_bank[b] = mem_q[y_ofs_i];

    AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(x_sel && y_sel)) else $error("two writers on bank %0d", b); // R4
  end

  assign x_rdata_o = x_rd_bank[x_bank_i];
  assign y_rdata_o = y_rd_bank[y_bank_i];
endmodule

// File: rtl/dpb_arbiter_top.sv
module dpb_arbiter_top
  import dpb_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned BANKS  = DEF_BANKS,
  parameter int unsigned OFS_W  = DEF_OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x_req_i,
  input  logic              x_we_i,
  input  logic [ADDR_W-1:0] x_addr_i,
  input  logic [DATA_W-1:0] x_wdata_i,
  input  logic              y_req_i,
  input  logic              y_we_i,
  input  logic [ADDR_W-1:0] y_addr_i,
  input  logic [DATA_W-1:0] y_wdata_i,
  output logic [DATA_W-1:0] x_rdata_o,
  output logic [DATA_W-1:0] y_rdata_o,
  output logic              x_ready_o,
  output logic              y_ready_o,
  output logic              stall_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);

  logic [BANK_W-1:0] x_bank, y_bank;
  logic [OFS_W-1:0]  x_ofs, y_ofs;
  logic              collide, x_wait;
  port_stat_t        x_st, y_st;

  dpb_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_x_split (
    .addr_i(x_addr_i), .bank_o(x_bank), .ofs_o(x_ofs)
  );
  dpb_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_y_split (
    .addr_i(y_addr_i), .bank_o(y_bank), .ofs_o(y_ofs)
  );

  assign collide = x_req_i & y_req_i & (x_bank == y_bank);
  // data bus owns a shared bank until its access has completed
  assign x_wait  = collide & ~y_st.done;

  dpb_port_seq u_y_seq (
    .clk_i, .rst_ni, .req_i(y_req_i), .we_i(y_we_i),
    .wait_i(1'b0), .stall_i(stall_o), .stat_o(y_st)
  );
  dpb_port_seq u_x_seq (
    .clk_i, .rst_ni, .req_i(x_req_i), .we_i(x_we_i),
    .wait_i(x_wait), .stall_i(stall_o), .stat_o(x_st)
  );

  assign stall_o   = x_st.pend | y_st.pend;
  assign x_ready_o = x_st.fin;
  assign y_ready_o = y_st.fin;

  dpb_bank_mem #(.DATA_W(DATA_W), .BANKS(BANKS), .OFS_W(OFS_W)) u_mem (
    .clk_i, .rst_ni,
    .x_bank_i(x_bank), .x_ofs_i(x_ofs), .x_wr_i(x_st.fin & x_we_i),
    .x_wdata_i(x_wdata_i), .x_rdata_o(x_rdata_o),
    .y_bank_i(y_bank), .y_ofs_i(y_ofs), .y_wr_i(y_st.fin & y_we_i),
    .y_wdata_i(y_wdata_i), .y_rdata_o(y_rdata_o)
  );

  AST_SPLIT_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_req_i && y_req_i && !x_we_i && !y_we_i && x_bank != y_bank && !x_st.done && !y_st.done)
      |-> (x_ready_o && y_ready_o && !stall_o)) else $error("split reads stalled"); // R3
  AST_Y_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collide && !y_st.done) |-> !x_ready_o) else $error("X served ahead of Y"); // R4
  AST_X_WRITE_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_ready_o && x_we_i) |-> ($past(x_req_i) && $past(stall_o))) else $error("X write too short"); // R5
  AST_Y_WRITE_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_ready_o && y_we_i) |-> ($past(y_req_i) && $past(stall_o))) else $error("Y write too short"); // R5
  AST_END_X_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && x_req_i) |-> (x_ready_o || x_st.done)) else $error("stall dropped with X open"); // R6
  AST_END_Y_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && y_req_i) |-> (y_ready_o || y_st.done)) else $error("stall dropped with Y open"); // R6
  AST_X_READY_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_ready_o && stall_o) |=> !x_ready_o) else $error("X ready repeated"); // R8
  AST_Y_READY_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_ready_o && stall_o) |=> !y_ready_o) else $error("Y ready repeated"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((x_ready_o && !x_req_i) || (y_ready_o && !y_req_i))) else $error("ready without request"); // R9
endmodule

// File: tb/tb_dpb_arbiter_top.sv
`timescale 1ns/1ps
module tb_dpb_arbiter_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_req = 0, x_we = 0, y_req = 0, y_we = 0;
  logic [15:0] x_addr = '0, x_wdata = '0, y_addr = '0, y_wdata = '0;
  logic [15:0] x_rdata, y_rdata;
  logic x_ready, y_ready, stall;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dpb_arbiter_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .x_req_i(x_req), .x_we_i(x_we), .x_addr_i(x_addr), .x_wdata_i(x_wdata),
    .y_req_i(y_req), .y_we_i(y_we), .y_addr_i(y_addr), .y_wdata_i(y_wdata),
    .x_rdata_o(x_rdata), .y_rdata_o(y_rdata),
    .x_ready_o(x_ready), .y_ready_o(y_ready), .stall_o(stall)
  );

  typedef struct packed {
    logic xq; logic xw; logic [15:0] xa; logic [15:0] xd;
    logic yq; logic yw; logic [15:0] ya; logic [15:0] yd;
    logic [2:0] n; logic [2:0] xc; logic [2:0] yc;
    logic [15:0] xe; logic [15:0] ye;
  } vec_t;

  // n = cycles in transaction, xc/yc = ready cycle (7: none), xe/ye = read data
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,16'h0010,16'hA001, 1'b1,1'b1,16'h4020,16'hB002, 3'd2,3'd1,3'd1, 16'h0,16'h0},
    '{1'b1,1'b0,16'h0010,16'h0,    1'b1,1'b0,16'h4020,16'h0,    3'd1,3'd0,3'd0, 16'hA001,16'hB002},
    '{1'b1,1'b0,16'h0010,16'h0,    1'b1,1'b1,16'h0011,16'hC003, 3'd3,3'd2,3'd1, 16'hA001,16'h0},
    '{1'b1,1'b0,16'h0010,16'h0,    1'b1,1'b0,16'h0011,16'h0,    3'd2,3'd1,3'd0, 16'hA001,16'hC003},
    '{1'b1,1'b0,16'h8005,16'h0,    1'b1,1'b1,16'h8005,16'hD004, 3'd3,3'd2,3'd1, 16'hD004,16'h0},
    '{1'b1,1'b1,16'h8005,16'hE005, 1'b1,1'b0,16'h8005,16'h0,    3'd3,3'd2,3'd0, 16'h0,16'hD004},
    '{1'b1,1'b1,16'hC001,16'h1111, 1'b1,1'b1,16'hC002,16'h2222, 3'd4,3'd3,3'd1, 16'h0,16'h0},
    '{1'b1,1'b0,16'hC002,16'h0,    1'b1,1'b0,16'hC001,16'h0,    3'd2,3'd1,3'd0, 16'h2222,16'h1111},
    '{1'b1,1'b0,16'h3F10,16'h0,    1'b1,1'b0,16'h8005,16'h0,    3'd1,3'd0,3'd0, 16'hA001,16'hE005},
    '{1'b0,1'b0,16'h0,16'h0,       1'b1,1'b0,16'h4020,16'h0,    3'd1,3'd7,3'd0, 16'h0,16'hB002},
    '{1'b1,1'b1,16'h4030,16'h7777, 1'b0,1'b0,16'h0,16'h0,       3'd2,3'd1,3'd7, 16'h0,16'h0},
    '{1'b1,1'b0,16'h4030,16'h0,    1'b1,1'b1,16'h8010,16'h3333, 3'd2,3'd0,3'd1, 16'h7777,16'h0},
    '{1'b1,1'b0,16'h8010,16'h0,    1'b0,1'b0,16'h0,16'h0,       3'd1,3'd0,3'd7, 16'h3333,16'h0}
  };

  task automatic chk(input string tag, input int idx, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (step %0d): actual=%h expected=%h", tag, idx, act, exp);
    end
  endtask

  task automatic idle_inputs();
    x_req = 0; x_we = 0; y_req = 0; y_we = 0;
    x_addr = '0; y_addr = '0; x_wdata = '0; y_wdata = '0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 stall in reset", 0, 16'(stall), 16'h0);
    chk("R1 x_ready in reset", 0, 16'(x_ready), 16'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 stall after reset", 0, 16'(stall), 16'h0);
    chk("R1 y_ready after reset", 0, 16'(y_ready), 16'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < int'(VECS[v].n); c++) begin
        @(negedge clk);
        if (c == 0) begin
          x_req = VECS[v].xq; x_we = VECS[v].xw; x_addr = VECS[v].xa; x_wdata = VECS[v].xd;
          y_req = VECS[v].yq; y_we = VECS[v].yw; y_addr = VECS[v].ya; y_wdata = VECS[v].yd;
        end
        #1;
        chk("R5 R6 stall", v*8+c, 16'(stall), 16'(c < int'(VECS[v].n) - 1));
        chk("R3 R4 R5 R8 x_ready", v*8+c, 16'(x_ready), 16'(c == int'(VECS[v].xc)));
        chk("R3 R4 R5 R8 y_ready", v*8+c, 16'(y_ready), 16'(c == int'(VECS[v].yc)));
        if (VECS[v].xq && !VECS[v].xw && c == int'(VECS[v].xc))
          chk("R2 R7 x_rdata", v*8+c, x_rdata, VECS[v].xe);
        if (VECS[v].yq && !VECS[v].yw && c == int'(VECS[v].yc))
          chk("R2 R7 y_rdata", v*8+c, y_rdata, VECS[v].ye);
      end
      @(negedge clk);
      idle_inputs();
    end

    // R9 write-enable without request is ignored
    @(negedge clk);
    x_we = 1; x_addr = 16'h0010; x_wdata = 16'hFFFF;
    y_we = 1; y_addr = 16'h4020; y_wdata = 16'hEEEE;
    #1;
    chk("R9 x_ready without req", 200, 16'(x_ready), 16'h0);
    chk("R9 stall without req", 200, 16'(stall), 16'h0);
    @(negedge clk); #1;
    chk("R9 y_ready without req", 201, 16'(y_ready), 16'h0);
    @(negedge clk);
    idle_inputs();
    x_req = 1; x_addr = 16'h0010; y_req = 1; y_addr = 16'h4020;
    #1;
    chk("R9 x word untouched", 202, x_rdata, 16'hA001);
    chk("R9 y word untouched", 202, y_rdata, 16'hB002);
    chk("R3 split read no stall", 202, 16'(stall), 16'h0);

    // R2 alias through the middle bits on the Y side
    @(negedge clk);
    idle_inputs();
    y_req = 1; y_addr = 16'h4A20;
    #1;
    chk("R2 aliased y read", 203, y_rdata, 16'hB002);
    @(negedge clk);
    idle_inputs();
    @(negedge clk); #1;
    chk("R1 idle quiet", 204, 16'({x_ready, y_ready, stall}), 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule